// File: doc/BRIEF.md
# Serial Port Register Bank Decoder

This block is the memory-mapped front end of a serial port. It owns a 4 KB address window addressed in 32-bit words (the byte offset shifted right by two). It decodes single-cycle read and write requests, keeps the configuration registers (baud divisors, line and port control, FIFO trigger levels, interrupt mask, DMA control), gathers interrupt sources into a raw status word, and serves eight fixed identification bytes in the last eight words of the window.

The serial shifters and the FIFO storage sit outside. The block meets them through a few signals. A write to the data word produces a one-cycle transmit push carrying the byte. A read of the data word returns the receive word presented by the FIFO and produces a one-cycle pop. A change of the line-control FIFO-enable bit produces a flush pulse. The FIFO status lines are sampled into the flag word. The block also reports a baud rate. It takes this rate from the two divisors and a clock frequency given as a parameter.

Each request is presented for one cycle. The response appears on the cycle after the request. Offsets that have no register behind them read as zero and produce a one-cycle bad-access pulse.

Top module: `uart_regbank`

## Requirements
- R1: After reset, reads return 0x90 for the flag word (index 6), 0x300 for port control (index 12) and 0x12 for FIFO level select (index 13). The interrupt mask (14), raw status (15) and the other stored words all read 0, and the baud output is 0.
- R2: A read request gives `rsp_valid` high, with its data, on the cycle after the request. A write request never raises `rsp_valid`.
- R3: The stored words read back what was written, cut to their widths:
  - low-power divisor (index 8): 8 bits
  - integer divisor (9): 16 bits
  - fractional divisor (10): 6 bits
  - line control (11): 8 bits
  - port control (12): 16 bits
  - FIFO level (13): 6 bits
  - interrupt mask (14): 11 bits
  - DMA control (18): 3 bits
- R4: Writes to the flag word (index 6) are ignored. Each cycle the flag word is refreshed from the FIFO status inputs, and it reads with the following bits, all other bits zero:
  - transmit empty in bit 7
  - receive full in bit 6
  - transmit full in bit 5
  - receive empty in bit 4
- R5: Byte offsets 0xFE0, 0xFE4, … 0xFFC read the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, each in bits 7:0.
- R6: A bad access is any of the following:
  - a read of an unmapped index, or of the interrupt clear word (17)
  - a write to an unmapped index
  - a write to raw status (15), masked status (16) or the identification block

  A bad read returns 0. Every bad access raises `bad_access` for exactly the response cycle and changes no register.
- R7: A write to index 0 pulses `tx_push` for one cycle with `tx_data` equal to write bits 7:0. It also sets raw status bit 5.
- R8: A read of index 0 returns the 12-bit `rx_word` (data in bits 7:0, receive status in bits 11:8) and pulses `rx_pop`. It captures bits 11:8 into the receive status word (index 1). Any write to index 1 clears that word.
- R9: Raw status bits are set by `int_raise`. Writing ones to index 17 clears the matching bits, and a raise in the same cycle as a clear wins. Masked status (16) reads raw AND mask, and `irq_any` is high whenever that value is nonzero.
- R10: `baud_rate` equals floor(CLK_HZ / (integer divisor × 64 + fractional divisor)) × 4. It is 0 whenever the fractional divisor is 0.
- R11: A write to DMA control (18) whose bits 1:0 are not both zero pulses `dma_unsup` for one cycle.
- R12: A write to line control (11) that changes bit 4 pulses `fifo_flush` for one cycle. A write that leaves bit 4 unchanged does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | One-cycle pulse for an unmapped or illegal access |
| rx_word | input | 12 | Head receive entry from the FIFO |
| rx_pop | output | 1 | Pop the receive FIFO |
| tx_push | output | 1 | Push a byte into the transmit FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| fifo_flush | output | 1 | FIFO enable changed, flush both FIFOs |
| st_tx_empty | input | 1 | Transmit FIFO empty |
| st_rx_full | input | 1 | Receive FIFO full |
| st_tx_full | input | 1 | Transmit FIFO full |
| st_rx_empty | input | 1 | Receive FIFO empty |
| int_raise | input | 11 | Interrupt source set pulses |
| irq_any | output | 1 | Any enabled interrupt pending |
| dma_unsup | output | 1 | Unsupported DMA request pulse |
| baud_rate | output | 32 | Derived baud rate |

## Verification
The assertions assume that requests arrive one per cycle with `req_write` and `req_addr` settled at the sampling edge. They also assume that `int_raise` is a level sampled once per cycle. Nothing ties it to the clear write, so a raise and a clear in the same cycle are legal. The directed stimulus drives every input on the falling edge and holds it for exactly one rising edge. It reads results half a cycle after the edge that registers them. It deliberately places one raise on the same edge as a clear, so that the set-wins ordering is checked.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_RXSTAT, SEL_FLAGS, SEL_IRDA, SEL_DIVINT,
    SEL_DIVFRAC, SEL_LINE, SEL_CTRL, SEL_LEVEL, SEL_MASK, SEL_RAW,
    SEL_MASKED, SEL_CLEAR, SEL_DMA, SEL_IDENT
  } reg_sel_e;

  localparam int INT_BITS  = 11;
  localparam int TX_INT    = 5;
  localparam int FIFO_EN   = 4;

  function automatic logic [7:0] ident_byte(input logic [2:0] slot);
    case (slot)
      3'd0:    return 8'h11;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [2:0]        id_slot
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] ID_BASE = IDX_W'((1 << IDX_W) - 8);

  logic [IDX_W-1:0] idx;
  assign idx     = addr[ADDR_W-1:2];
  assign id_slot = idx[2:0];

  always_comb begin
    if (idx >= ID_BASE) begin
      sel = SEL_IDENT;
    end else begin
      case (idx)
        IDX_W'(0):  sel = SEL_DATA;
        IDX_W'(1):  sel = SEL_RXSTAT;
        IDX_W'(6):  sel = SEL_FLAGS;
        IDX_W'(8):  sel = SEL_IRDA;
        IDX_W'(9):  sel = SEL_DIVINT;
        IDX_W'(10): sel = SEL_DIVFRAC;
        IDX_W'(11): sel = SEL_LINE;
        IDX_W'(12): sel = SEL_CTRL;
        IDX_W'(13): sel = SEL_LEVEL;
        IDX_W'(14): sel = SEL_MASK;
        IDX_W'(15): sel = SEL_RAW;
        IDX_W'(16): sel = SEL_MASKED;
        IDX_W'(17): sel = SEL_CLEAR;
        IDX_W'(18): sel = SEL_DMA;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    rd_ok = (sel != SEL_NONE) && (sel != SEL_CLEAR);
    wr_ok = (sel != SEL_NONE) && (sel != SEL_RAW) &&
            (sel != SEL_MASKED) && (sel != SEL_IDENT);
  end

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq_any
);
  logic [N-1:0] raw_d, mask_d;

  always_comb begin
    raw_d  = raw;
    if (clr_en) raw_d = raw_d & ~clr_bits;
    raw_d  = raw_d | raise;
    mask_d = mask_we ? mask_wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_d;
      mask <= mask_d;
    end
  end

  assign masked  = raw & mask;
  assign irq_any = |masked;

  // R9: a raised source is pending on the next cycle, even under a clear
  a_r9_raise_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (raise != '0) |=> ((raw & $past(raise)) == $past(raise)));

  // R9: a cleared bit without a raise is gone on the next cycle
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && raise == '0) |=> ((raw & $past(clr_bits)) == '0));

endmodule

// File: rtl/uart_rb_baud.sv
module uart_rb_baud #(
  parameter int unsigned CLK_HZ = 24_000_000,
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6,
  parameter int BAUD_W  = 32
) (
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic [BAUD_W-1:0] baud
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam logic [BAUD_W-1:0] CLK_V = BAUD_W'(CLK_HZ);

  logic [DIV_W-1:0]  divisor;
  logic [BAUD_W-1:0] quot;

  assign divisor = {div_int, div_frac};

  always_comb begin
    if (div_frac == '0) begin
      quot = '0;
      baud = '0;
    end else begin
      quot = CLK_V / BAUD_W'(divisor);
      baud = quot << 2;
    end
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int unsigned CLK_HZ = 24_000_000,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RXST_W   = 4,
  parameter int DIVI_W   = 16,
  parameter int DIVF_W   = 6,
  parameter int LINE_W   = 8,
  parameter int CTRL_W   = 16,
  parameter int LEVEL_W  = 6,
  parameter int DMA_W    = 3,
  parameter int BAUD_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       bad_access,
  input  logic [BYTE_W+RXST_W-1:0]   rx_word,
  output logic                       rx_pop,
  output logic                       tx_push,
  output logic [BYTE_W-1:0]          tx_data,
  output logic                       fifo_flush,
  input  logic                       st_tx_empty,
  input  logic                       st_rx_full,
  input  logic                       st_tx_full,
  input  logic                       st_rx_empty,
  input  logic [INT_BITS-1:0]        int_raise,
  output logic                       irq_any,
  output logic                       dma_unsup,
  output logic [BAUD_W-1:0]          baud_rate
);
  localparam int RXW = BYTE_W + RXST_W;
  localparam logic [CTRL_W-1:0]  CTRL_RST  = CTRL_W'(16'h0300);
  localparam logic [LEVEL_W-1:0] LEVEL_RST = LEVEL_W'(6'h12);
  localparam logic [3:0]         FLAG_RST  = 4'b1001;

  reg_sel_e   sel;
  logic       rd_ok, wr_ok;
  logic [2:0] id_slot;
  logic       rd, wr;

  uart_rb_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr(req_addr), .sel(sel), .rd_ok(rd_ok), .wr_ok(wr_ok), .id_slot(id_slot)
  );

  assign rd = req_valid && !req_write;
  assign wr = req_valid &&  req_write;

  // stored configuration
  logic [BYTE_W-1:0]  irda_q,  irda_d;
  logic [DIVI_W-1:0]  divi_q,  divi_d;
  logic [DIVF_W-1:0]  divf_q,  divf_d;
  logic [LINE_W-1:0]  line_q,  line_d;
  logic [CTRL_W-1:0]  ctrl_q,  ctrl_d;
  logic [LEVEL_W-1:0] level_q, level_d;
  logic [DMA_W-1:0]   dma_q,   dma_d;
  logic [RXST_W-1:0]  rxst_q,  rxst_d;
  logic [3:0]         flag_q,  flag_d;

  // response and pulses
  logic              rspv_d, bad_d, pop_d, push_d, flush_d, unsup_d;
  logic [DATA_W-1:0] rdata_d;
  logic [BYTE_W-1:0] txd_d;

  // interrupt unit
  logic [INT_BITS-1:0] raw, mask, masked, raise_all;
  logic                clr_en, mask_we, tx_set;

  assign tx_set    = wr && (sel == SEL_DATA);
  assign raise_all = int_raise | (INT_BITS'(tx_set) << TX_INT);
  assign clr_en    = wr && (sel == SEL_CLEAR);
  assign mask_we   = wr && (sel == SEL_MASK);

  uart_rb_irq #(.N(INT_BITS)) i_irq (
    .clk(clk), .rst_n(rst_n), .raise(raise_all),
    .clr_en(clr_en), .clr_bits(req_wdata[INT_BITS-1:0]),
    .mask_we(mask_we), .mask_wdata(req_wdata[INT_BITS-1:0]),
    .raw(raw), .mask(mask), .masked(masked), .irq_any(irq_any)
  );

  uart_rb_baud #(
    .CLK_HZ(CLK_HZ), .INT_W(DIVI_W), .FRAC_W(DIVF_W), .BAUD_W(BAUD_W)
  ) i_baud (
    .div_int(divi_q), .div_frac(divf_q), .baud(baud_rate)
  );

  // register next state
  always_comb begin
    irda_d  = irda_q;
    divi_d  = divi_q;
    divf_d  = divf_q;
    line_d  = line_q;
    ctrl_d  = ctrl_q;
    level_d = level_q;
    dma_d   = dma_q;
    rxst_d  = rxst_q;
    flag_d  = {st_tx_empty, st_rx_full, st_tx_full, st_rx_empty};
    push_d  = 1'b0;
    txd_d   = tx_data;
    flush_d = 1'b0;
    unsup_d = 1'b0;
    pop_d   = 1'b0;
    if (wr) begin
      case (sel)
        SEL_DATA: begin
          push_d = 1'b1;
          txd_d  = req_wdata[BYTE_W-1:0];
        end
        SEL_RXSTAT:  rxst_d  = '0;
        SEL_IRDA:    irda_d  = req_wdata[BYTE_W-1:0];
        SEL_DIVINT:  divi_d  = req_wdata[DIVI_W-1:0];
        SEL_DIVFRAC: divf_d  = req_wdata[DIVF_W-1:0];
        SEL_LINE: begin
          line_d  = req_wdata[LINE_W-1:0];
          flush_d = line_q[FIFO_EN] ^ req_wdata[FIFO_EN];
        end
        SEL_CTRL:    ctrl_d  = req_wdata[CTRL_W-1:0];
        SEL_LEVEL:   level_d = req_wdata[LEVEL_W-1:0];
        SEL_DMA: begin
          dma_d   = req_wdata[DMA_W-1:0];
          unsup_d = |req_wdata[1:0];
        end
        default: ;
      endcase
    end
    if (rd && sel == SEL_DATA) begin
      pop_d  = 1'b1;
      rxst_d = rx_word[RXW-1:BYTE_W];
    end
  end

  // read data mux
  always_comb begin
    rdata_d = '0;
    if (rd) begin
      case (sel)
        SEL_DATA:    rdata_d = DATA_W'(rx_word);
        SEL_RXSTAT:  rdata_d = DATA_W'(rxst_q);
        SEL_FLAGS:   rdata_d = DATA_W'({flag_q, 4'b0000});
        SEL_IRDA:    rdata_d = DATA_W'(irda_q);
        SEL_DIVINT:  rdata_d = DATA_W'(divi_q);
        SEL_DIVFRAC: rdata_d = DATA_W'(divf_q);
        SEL_LINE:    rdata_d = DATA_W'(line_q);
        SEL_CTRL:    rdata_d = DATA_W'(ctrl_q);
        SEL_LEVEL:   rdata_d = DATA_W'(level_q);
        SEL_MASK:    rdata_d = DATA_W'(mask);
        SEL_RAW:     rdata_d = DATA_W'(raw);
        SEL_MASKED:  rdata_d = DATA_W'(masked);
        SEL_DMA:     rdata_d = DATA_W'(dma_q);
        SEL_IDENT:   rdata_d = DATA_W'(ident_byte(id_slot));
        default:     rdata_d = '0;
      endcase
    end
    rspv_d = rd;
    bad_d  = req_valid && (req_write ? !wr_ok : !rd_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irda_q  <= '0;
      divi_q  <= '0;
      divf_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= CTRL_RST;
      level_q <= LEVEL_RST;
      dma_q   <= '0;
      rxst_q  <= '0;
      flag_q  <= FLAG_RST;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      bad_access <= 1'b0;
      rx_pop     <= 1'b0;
      tx_push    <= 1'b0;
      tx_data    <= '0;
      fifo_flush <= 1'b0;
      dma_unsup  <= 1'b0;
    end else begin
      irda_q  <= irda_d;
      divi_q  <= divi_d;
      divf_q  <= divf_d;
      line_q  <= line_d;
      ctrl_q  <= ctrl_d;
      level_q <= level_d;
      dma_q   <= dma_d;
      rxst_q  <= rxst_d;
      flag_q  <= flag_d;
      rsp_valid  <= rspv_d;
      rsp_rdata  <= rdata_d;
      bad_access <= bad_d;
      rx_pop     <= pop_d;
      tx_push    <= push_d;
      tx_data    <= txd_d;
      fifo_flush <= flush_d;
      dma_unsup  <= unsup_d;
    end
  end

  // R2: every read is answered on the next cycle
  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2: a write never produces a response
  a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  // R6: a bad read returns zero
  a_r6_bad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_access && rsp_valid) |-> (rsp_rdata == '0));

  // R7: a transmit push only follows a write of word 0
  a_r7_push_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(req_valid && req_write && req_addr[ADDR_W-1:2] == '0));

  // R8: a pop accompanies a read response
  a_r8_pop_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rsp_valid && !bad_access));

  // R11: the unsupported flag follows a write only
  a_r11_unsup_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    dma_unsup |-> $past(req_valid && req_write));

endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  localparam time CLK_PERIOD = 10ns;
  localparam longint CLK_HZ  = 24_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, bad_access, rx_pop, tx_push, fifo_flush;
  logic        irq_any, dma_unsup;
  logic [31:0] rsp_rdata, baud_rate;
  logic [11:0] rx_word;
  logic [7:0]  tx_data;
  logic        st_tx_empty, st_rx_full, st_tx_full, st_rx_empty;
  logic [10:0] int_raise;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] c_rdata;
  logic        c_valid, c_bad, c_pop, c_push, c_flush, c_unsup;
  logic [7:0]  c_txd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank #(.CLK_HZ(24_000_000)) i_uart_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bad_access(bad_access), .rx_word(rx_word),
    .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data),
    .fifo_flush(fifo_flush), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .st_tx_full(st_tx_full), .st_rx_empty(st_rx_empty), .int_raise(int_raise),
    .irq_any(irq_any), .dma_unsup(dma_unsup), .baud_rate(baud_rate)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [10:0] rs);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; int_raise = rs;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; int_raise = '0;
    c_rdata = rsp_rdata; c_valid = rsp_valid; c_bad = bad_access;
    c_pop = rx_pop; c_push = tx_push; c_txd = tx_data;
    c_flush = fifo_flush; c_unsup = dma_unsup;
  endtask

  task automatic rd(input logic [11:0] a);
    access(1'b0, a, 32'h0, '0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    access(1'b1, a, d, '0);
  endtask

  function automatic logic [31:0] exp_baud(input longint ib, input longint fb);
    if (fb == 0) return 32'h0;
    return 32'((CLK_HZ / (ib * 64 + fb)) * 4);
  endfunction

  task automatic t_reset();
    rd(12'h018); chk("R1 flags reset", c_rdata, 32'h90);
    chk("R2 read valid", {31'b0, c_valid}, 32'h1);
    rd(12'h030); chk("R1 control reset", c_rdata, 32'h300);
    rd(12'h034); chk("R1 level reset", c_rdata, 32'h12);
    rd(12'h038); chk("R1 mask reset", c_rdata, 32'h0);
    rd(12'h03C); chk("R1 raw reset", c_rdata, 32'h0);
    chk("R1 baud reset", baud_rate, 32'h0);
  endtask

  task automatic t_storage();
    wr(12'h020, 32'hFFFF_FF5A); chk("R2 write no rsp", {31'b0, c_valid}, 32'h0);
    rd(12'h020); chk("R3 irda", c_rdata, 32'h5A);
    wr(12'h024, 32'h0001_BCDE); rd(12'h024); chk("R3 divint", c_rdata, 32'hBCDE);
    wr(12'h028, 32'hFF); rd(12'h028); chk("R3 divfrac", c_rdata, 32'h3F);
    wr(12'h030, 32'h1_2345); rd(12'h030); chk("R3 control", c_rdata, 32'h2345);
    wr(12'h034, 32'hFF); rd(12'h034); chk("R3 level", c_rdata, 32'h3F);
    wr(12'h038, 32'hFFFF); rd(12'h038); chk("R3 mask", c_rdata, 32'h7FF);
    wr(12'h038, 32'h0);
  endtask

  task automatic t_flags();
    wr(12'h018, 32'h0); rd(12'h018); chk("R4 flag write ignored", c_rdata, 32'h90);
    @(negedge clk);
    st_tx_empty = 1'b0; st_rx_full = 1'b1; st_tx_full = 1'b1; st_rx_empty = 1'b0;
    rd(12'h018); chk("R4 flags follow status", c_rdata, 32'h60);
    st_tx_empty = 1'b1; st_rx_full = 1'b0; st_tx_full = 1'b0; st_rx_empty = 1'b1;
  endtask

  task automatic t_ident();
    logic [7:0] exp_id [8];
    exp_id = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(k * 4));
      chk("R5 ident byte", c_rdata, {24'b0, exp_id[k]});
    end
  endtask

  task automatic t_bad();
    rd(12'h008); chk("R6 unmapped read zero", c_rdata, 32'h0);
    chk("R6 unmapped read flag", {31'b0, c_bad}, 32'h1);
    @(negedge clk); chk("R6 flag one cycle", {31'b0, bad_access}, 32'h0);
    rd(12'h044); chk("R6 clear read bad", {31'b0, c_bad}, 32'h1);
    wr(12'h03C, 32'h7FF); chk("R6 raw write bad", {31'b0, c_bad}, 32'h1);
    rd(12'h03C); chk("R6 raw unchanged", c_rdata, 32'h0);
    chk("R6 good read no flag", {31'b0, c_bad}, 32'h0);
    wr(12'h04C, 32'h1); chk("R6 unmapped write bad", {31'b0, c_bad}, 32'h1);
    chk("R6 unmapped write no dma flag", {31'b0, c_unsup}, 32'h0);
  endtask

  task automatic t_tx();
    wr(12'h000, 32'h1A5);
    chk("R7 push", {31'b0, c_push}, 32'h1);
    chk("R7 push byte", {24'b0, c_txd}, 32'hA5);
    rd(12'h03C); chk("R7 raw tx bit", c_rdata, 32'h20);
    chk("R7 no push on read", {31'b0, c_push}, 32'h0);
  endtask

  task automatic t_rx();
    rx_word = 12'h437;
    rd(12'h000); chk("R8 rx word", c_rdata, 32'h437);
    chk("R8 pop", {31'b0, c_pop}, 32'h1);
    rd(12'h004); chk("R8 status captured", c_rdata, 32'h4);
    chk("R8 no pop elsewhere", {31'b0, c_pop}, 32'h0);
    wr(12'h004, 32'h0); rd(12'h004); chk("R8 status cleared", c_rdata, 32'h0);
  endtask

  task automatic t_irq();
    chk("R9 idle irq", {31'b0, irq_any}, 32'h0);
    wr(12'h038, 32'h20);
    chk("R9 irq on enable", {31'b0, irq_any}, 32'h1);
    rd(12'h040); chk("R9 masked", c_rdata, 32'h20);
    wr(12'h044, 32'h20);
    chk("R9 irq cleared", {31'b0, irq_any}, 32'h0);
    rd(12'h03C); chk("R9 raw cleared", c_rdata, 32'h0);
    access(1'b0, 12'h038, 32'h0, 11'h400);
    rd(12'h03C); chk("R9 raise", c_rdata, 32'h400);
    rd(12'h040); chk("R9 masked hides", c_rdata, 32'h0);
    access(1'b1, 12'h044, 32'h400, 11'h400);
    rd(12'h03C); chk("R9 raise beats clear", c_rdata, 32'h400);
    wr(12'h044, 32'h7FF); wr(12'h038, 32'h0);
  endtask

  task automatic t_baud();
    wr(12'h024, 32'd13); wr(12'h028, 32'd1);
    chk("R10 baud 13.1", baud_rate, exp_baud(13, 1));
    wr(12'h028, 32'd0); chk("R10 zero frac", baud_rate, 32'h0);
    wr(12'h024, 32'd0); wr(12'h028, 32'd8);
    chk("R10 frac only", baud_rate, exp_baud(0, 8));
  endtask

  task automatic t_dma();
    wr(12'h048, 32'h4); chk("R11 bit2 no flag", {31'b0, c_unsup}, 32'h0);
    wr(12'h048, 32'h1); chk("R11 bit0 flag", {31'b0, c_unsup}, 32'h1);
    rd(12'h048); chk("R11 readback", c_rdata, 32'h1);
    wr(12'h048, 32'h2); chk("R11 bit1 flag", {31'b0, c_unsup}, 32'h1);
  endtask

  task automatic t_flush();
    wr(12'h02C, 32'h10); chk("R12 enable flush", {31'b0, c_flush}, 32'h1);
    wr(12'h02C, 32'h70); chk("R12 same no flush", {31'b0, c_flush}, 32'h0);
    wr(12'h02C, 32'h60); chk("R12 disable flush", {31'b0, c_flush}, 32'h1);
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rx_word = '0; int_raise = '0;
    st_tx_empty = 1'b1; st_rx_full = 1'b0; st_tx_full = 1'b0; st_rx_empty = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_flags();
    t_ident();
    t_bad();
    t_tx();
    t_rx();
    t_irq();
    t_baud();
    t_dma();
    t_flush();
    done = 1;
    summary();
  end

endmodule